// File: doc/BRIEF.md
# USB Host Channel Controller

This block is the control core of one transfer channel in a USB 2.0 host controller. Software programs a 32-bit characteristics register that holds the device address, the endpoint type, a low-speed flag, a frame-parity selector and a 2-bit count field. Writing the enable bit starts the channel. From then on the block asks a packet engine for transactions through a request/acknowledge/done handshake. Only the hardware clears the enable again. It does so when the transfer completes, when a software abort has been honoured, or when the split retry budget is used up. Each of these raises a sticky halted interrupt.

For periodic endpoints (isochronous, interrupt), the block gates transactions by microframe. It latches the parity of the frame number at each microframe-start strobe and issues transactions only in microframes whose parity matches the selector bit. It also caps how many transactions it issues in one microframe. The meaning of the 2-bit count field depends on the split-enable input. With split off, it is the number of transactions per microframe. With split on, it is the number of immediate retries after a transaction error.

Top module: `usb_hchan_ctrl`

## Requirements
- R1: After reset, `reg_rdata` reads 0, `irq_halted` is 0 and `txn_req` is 0.
- R2: Register fields are placed as follows: enable bit 31, abort bit 30, odd-frame bit 29, device address 28:22, count 21:20, endpoint type 19:18, low-speed bit 17. Bits 16:0 read 0. Bits 29:17 read back the value last written. A write of 1 to bit 30 while the channel is off (and bit 31 not written 1) is ignored.
- R3: Writing 1 to bit 31 sets the enable. Writing 0 there leaves it unchanged. Only the hardware clears it.
- R4: Endpoint type 00 is control, 01 isochronous, 10 bulk and 11 interrupt. Types 01 and 11 are periodic. An enabled non-periodic channel requests transactions without waiting for a microframe strobe and without any per-microframe limit.
- R5: A periodic channel requests only while the parity of the frame number latched at the last `uf_start` (bit 0 of `uf_num`) equals bit 29. Before the first strobe, the parity counts as even.
- R6: With split off, a periodic channel accepts at most N transactions per microframe, where N is the count field and 00 counts as 1. The tally restarts at each `uf_start` and when the channel is enabled.
- R7: With split on, a periodic channel accepts one transaction per microframe. After a done pulse with `txn_err`, the channel may re-request immediately, up to B times, where B is the count field and 00 counts as 1. The next error after B retries halts the channel.
- R8: A done pulse with `txn_last` (and no split error) clears the enable, and `irq_halted` is 1 from the next cycle.
- R9: Setting the abort bit while no transaction is in flight drops `txn_req` at once. On the following clock edge, the hardware clears bits 31 and 30 and sets `irq_halted`.
- R10: An abort set while a transaction is in flight waits for that transaction's done pulse. The halt (bits 31 and 30 cleared, `irq_halted` set) happens on the second clock edge after the cycle that carries the done pulse.
- R11: `irq_halted` stays set until a `sts_clr` pulse. A new halt in the same cycle takes priority over the clear.
- R12: At most one transaction is outstanding. After an accepted request (`txn_req` and `txn_ack` in the same cycle), `txn_req` stays low until `txn_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read value |
| sts_clr | input | 1 | Clears the halted interrupt |
| split_en | input | 1 | Selects the split meaning of the count field |
| uf_start | input | 1 | Microframe-start strobe |
| uf_num | input | FRAME_W | Current frame number, sampled with `uf_start` |
| txn_req | output | 1 | Transaction request to the packet engine |
| txn_ack | input | 1 | Packet engine accepts the request |
| txn_done | input | 1 | Outstanding transaction finished |
| txn_last | input | 1 | With `txn_done`: the transfer is complete |
| txn_err | input | 1 | With `txn_done`: the transaction failed |
| irq_halted | output | 1 | Sticky channel-halted interrupt |

## Verification
The hardest case to reach is an abort that lands while a transaction is outstanding. It needs a periodic channel in a matching microframe, an accepted request, and then a register write before the done pulse. The bench builds this by aligning the parity with a strobe, acknowledging a request, and only then writing the abort bit. It holds the done pulse back for several cycles and checks that no halt appears early. It then checks the exact edge on which the halt lands. A split channel is also driven through a full retry budget, so the halt on the error after the last permitted retry is observed.

// File: rtl/usb_hchan_pkg.sv
package usb_hchan_pkg;
   typedef enum logic [1:0] {
      EP_CTRL = 2'b00,
      EP_ISOC = 2'b01,
      EP_BULK = 2'b10,
      EP_INTR = 2'b11
   } ep_kind_e;

   localparam int unsigned B_EN      = 31;
   localparam int unsigned B_DIS     = 30;
   localparam int unsigned B_ODD     = 29;
   localparam int unsigned B_ADDR_LO = 22;
   localparam int unsigned B_CNT_LO  = 20;
   localparam int unsigned B_EP_LO   = 18;
   localparam int unsigned B_LS      = 17;

   function automatic logic ep_periodic(input ep_kind_e k);
      return (k == EP_ISOC) || (k == EP_INTR);
   endfunction

   // count field value with 00 promoted to one
   function automatic logic [1:0] cnt_floor1(input logic [1:0] v);
      return (v == 2'b00) ? 2'd1 : v;
   endfunction
endpackage

// File: rtl/usb_hchan_regs.sv
module usb_hchan_regs
   import usb_hchan_pkg::*;
#(
   parameter int unsigned REG_W  = 32,
   parameter int unsigned ADDR_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [REG_W-1:0]  wdata,
   input  logic              hw_clr,
   output logic              en,
   output logic              dis,
   output logic              odd,
   output logic [1:0]        cnt,
   output ep_kind_e          ep,
   output logic              start,
   output logic [REG_W-1:0]  rdata
);
   localparam int unsigned ADDR_HI = B_ADDR_LO + ADDR_W - 1;

   generate
      if (REG_W != 32) begin : g_bad_regw
         $error("usb_hchan_regs: REG_W must be 32");
      end
      if (ADDR_HI != B_ODD - 1) begin : g_bad_addrw
         $error("usb_hchan_regs: address field must end below the odd bit");
      end
   endgenerate

   logic [ADDR_W-1:0] addr;
   logic              ls;
   logic              unused_low;

   assign unused_low = ^wdata[B_LS-1:0];
   assign start      = wr && wdata[B_EN] && !en && !hw_clr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en   <= 1'b0;
         dis  <= 1'b0;
         odd  <= 1'b0;
         addr <= '0;
         cnt  <= 2'b00;
         ep   <= EP_CTRL;
         ls   <= 1'b0;
      end else begin
         if (wr) begin
            odd  <= wdata[B_ODD];
            addr <= wdata[ADDR_HI:B_ADDR_LO];
            cnt  <= wdata[B_CNT_LO +: 2];
            ep   <= ep_kind_e'(wdata[B_EP_LO +: 2]);
            ls   <= wdata[B_LS];
         end
         if (hw_clr) begin
            en  <= 1'b0;
            dis <= 1'b0;
         end else begin
            if (wr && wdata[B_EN])
               en <= 1'b1;
            if (wr && wdata[B_DIS] && (en || wdata[B_EN]))
               dis <= 1'b1;
         end
      end
   end

   always_comb begin
      rdata                       = '0;
      rdata[B_EN]                 = en;
      rdata[B_DIS]                = dis;
      rdata[B_ODD]                = odd;
      rdata[ADDR_HI:B_ADDR_LO]    = addr;
      rdata[B_CNT_LO +: 2]        = cnt;
      rdata[B_EP_LO +: 2]         = ep;
      rdata[B_LS]                 = ls;
   end
endmodule

// File: rtl/usb_hchan_sched.sv
module usb_hchan_sched
   import usb_hchan_pkg::*;
#(
   parameter int unsigned FRAME_W = 14
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               uf_start,
   input  logic [FRAME_W-1:0] uf_num,
   input  logic               start,
   input  logic               odd,
   input  logic               periodic,
   input  logic               split,
   input  logic [1:0]         cnt,
   input  logic               accept,
   input  logic               retry_pend,
   output logic               issue_ok
);
   generate
      if (FRAME_W < 1) begin : g_bad_fw
         $error("usb_hchan_sched: FRAME_W must be at least 1");
      end
      if (FRAME_W > 1) begin : g_wide
         logic unused_hi;
         assign unused_hi = ^uf_num[FRAME_W-1:1];
      end
   endgenerate

   logic       cur_odd;
   logic [1:0] uf_tally;
   logic [1:0] limit;

   assign limit    = split ? 2'd1 : cnt_floor1(cnt);
   assign issue_ok = !periodic ||
                     ((cur_odd == odd) && ((uf_tally < limit) || retry_pend));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_odd  <= 1'b0;
         uf_tally <= 2'd0;
      end else begin
         if (uf_start)
            cur_odd <= uf_num[0];
         if (uf_start || start)
            uf_tally <= 2'd0;
         else if (accept && !retry_pend && (uf_tally != 2'd3))
            uf_tally <= uf_tally + 2'd1;
      end
   end
endmodule

// File: rtl/usb_hchan_halt.sv
module usb_hchan_halt
   import usb_hchan_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       dis,
   input  logic       periodic,
   input  logic       split,
   input  logic [1:0] cnt,
   input  logic       start,
   input  logic       accept,
   input  logic       done,
   input  logic       last,
   input  logic       err,
   input  logic       sts_clr,
   output logic       inflight,
   output logic       retry_pend,
   output logic       hw_clr,
   output logic       irq
);
   logic [1:0] err_used;
   logic       split_err;
   logic       spent;
   logic       done_halt;

   assign split_err = done && err && split && periodic;
   assign spent     = err_used >= cnt_floor1(cnt);
   assign done_halt = done && ((err && split && periodic) ? spent : last);
   assign hw_clr    = en && (done_halt || (dis && !inflight));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         inflight   <= 1'b0;
         retry_pend <= 1'b0;
         err_used   <= 2'd0;
         irq        <= 1'b0;
      end else begin
         if (hw_clr || start)
            inflight <= 1'b0;
         else if (accept)
            inflight <= 1'b1;
         else if (done)
            inflight <= 1'b0;

         if (start)
            retry_pend <= 1'b0;
         else if (split_err && !spent)
            retry_pend <= 1'b1;
         else if (accept)
            retry_pend <= 1'b0;

         if (start || (done && !err))
            err_used <= 2'd0;
         else if (split_err && !spent)
            err_used <= err_used + 2'd1;

         if (hw_clr)
            irq <= 1'b1;
         else if (sts_clr)
            irq <= 1'b0;
      end
   end
endmodule

// File: rtl/usb_hchan_ctrl.sv
module usb_hchan_ctrl
   import usb_hchan_pkg::*;
#(
   parameter int unsigned REG_W   = 32,
   parameter int unsigned ADDR_W  = 7,
   parameter int unsigned FRAME_W = 14
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr,
   input  logic [REG_W-1:0]   reg_wdata,
   output logic [REG_W-1:0]   reg_rdata,
   input  logic               sts_clr,
   input  logic               split_en,
   input  logic               uf_start,
   input  logic [FRAME_W-1:0] uf_num,
   output logic               txn_req,
   input  logic               txn_ack,
   input  logic               txn_done,
   input  logic               txn_last,
   input  logic               txn_err,
   output logic               irq_halted
);
   logic       en, dis, odd, start, hw_clr;
   logic [1:0] cnt;
   ep_kind_e   ep;
   logic       periodic, accept, issue_ok, inflight, retry_pend;

   assign periodic = ep_periodic(ep);
   assign txn_req  = en && !dis && !inflight && issue_ok;
   assign accept   = txn_req && txn_ack;

   usb_hchan_regs #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(reg_wdata),
      .hw_clr(hw_clr), .en(en), .dis(dis), .odd(odd), .cnt(cnt),
      .ep(ep), .start(start), .rdata(reg_rdata)
   );

   usb_hchan_sched #(.FRAME_W(FRAME_W)) u_sched (
      .clk(clk), .rst_n(rst_n), .uf_start(uf_start), .uf_num(uf_num),
      .start(start), .odd(odd), .periodic(periodic), .split(split_en),
      .cnt(cnt), .accept(accept), .retry_pend(retry_pend),
      .issue_ok(issue_ok)
   );

   usb_hchan_halt u_halt (
      .clk(clk), .rst_n(rst_n), .en(en), .dis(dis), .periodic(periodic),
      .split(split_en), .cnt(cnt), .start(start), .accept(accept),
      .done(txn_done), .last(txn_last), .err(txn_err), .sts_clr(sts_clr),
      .inflight(inflight), .retry_pend(retry_pend), .hw_clr(hw_clr),
      .irq(irq_halted)
   );
endmodule

// File: rtl/usb_hchan_ctrl_chk.sv
module usb_hchan_ctrl_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        reg_wr,
   input logic        wr_en_bit,
   input logic [31:0] reg_rdata,
   input logic        split_en,
   input logic        uf_start,
   input logic        txn_req,
   input logic        txn_ack,
   input logic        txn_done,
   input logic        txn_last,
   input logic        txn_err,
   input logic        irq_halted
);
   logic [2:0] acc_cnt;
   logic [1:0] lim;
   logic       unused_rd;

   assign unused_rd = ^{reg_rdata[29:22], reg_rdata[19], reg_rdata[17:0]};
   assign lim = (reg_rdata[21:20] == 2'b00) ? 2'd1 : reg_rdata[21:20];

   always_ff @(posedge clk) begin
      if (!rst_n)
         acc_cnt <= 3'd0;
      else if (uf_start || (reg_wr && wr_en_bit && !reg_rdata[31]))
         acc_cnt <= 3'd0;
      else if (txn_req && txn_ack && acc_cnt != 3'd7)
         acc_cnt <= acc_cnt + 3'd1;
   end

   assert_one_outstanding_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_req && txn_ack) |=> !txn_req);

   assert_enable_from_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(reg_rdata[31]) |-> $past(reg_wr && wr_en_bit));

   assert_halt_clears_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_halted) |-> (!reg_rdata[31] && !reg_rdata[30]));

   assert_req_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      txn_req |-> (reg_rdata[31] && !reg_rdata[30]));

   assert_uf_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[31] && reg_rdata[18] && !split_en) |-> (acc_cnt <= {1'b0, lim}));

   assert_abort_waits_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_done && !txn_last && !txn_err && reg_rdata[31] && reg_rdata[30])
      |=> reg_rdata[31]);
endmodule

bind usb_hchan_ctrl usb_hchan_ctrl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .wr_en_bit(reg_wdata[31]),
   .reg_rdata(reg_rdata), .split_en(split_en), .uf_start(uf_start),
   .txn_req(txn_req), .txn_ack(txn_ack), .txn_done(txn_done),
   .txn_last(txn_last), .txn_err(txn_err), .irq_halted(irq_halted)
);

// File: tb/tb_usb_hchan_ctrl.sv
module tb_usb_hchan_ctrl;
   localparam int FW = 14;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic          sts_clr = 1'b0;
   logic          split_en = 1'b0;
   logic          uf_start = 1'b0;
   logic [FW-1:0] uf_num = '0;
   logic          txn_req;
   logic          txn_ack = 1'b0;
   logic          txn_done = 1'b0;
   logic          txn_last = 1'b0;
   logic          txn_err = 1'b0;
   logic          irq_halted;

   int total = 0;
   int bad   = 0;

   always #4 clk = ~clk;

   usb_hchan_ctrl #(.FRAME_W(FW)) dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .sts_clr(sts_clr), .split_en(split_en),
      .uf_start(uf_start), .uf_num(uf_num), .txn_req(txn_req),
      .txn_ack(txn_ack), .txn_done(txn_done), .txn_last(txn_last),
      .txn_err(txn_err), .irq_halted(irq_halted)
   );

   // write data / expected read-back, channel kept off
   localparam logic [63:0] VEC [5] = '{
      {32'h7FFF_FFFF, 32'h3FFE_0000},
      {32'h4000_0000, 32'h0000_0000},
      {32'h2A5A_5A5A, 32'h2A5A_0000},
      {32'h0001_FFFF, 32'h0000_0000},
      {32'h1C00_0000, 32'h1C00_0000}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [31:0] v);
      reg_wr = 1'b1; reg_wdata = v;
      step();
      reg_wr = 1'b0;
   endtask

   task automatic ack();
      txn_ack = 1'b1;
      step();
      txn_ack = 1'b0;
   endtask

   task automatic done(input logic last, input logic err);
      txn_done = 1'b1; txn_last = last; txn_err = err;
      step();
      txn_done = 1'b0; txn_last = 1'b0; txn_err = 1'b0;
   endtask

   task automatic ufs(input int n);
      uf_start = 1'b1; uf_num = FW'(n);
      step();
      uf_start = 1'b0;
   endtask

   task automatic clr();
      sts_clr = 1'b1;
      step();
      sts_clr = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step();
      // R1
      chk("R1 rdata", reg_rdata, 32'h0);
      chk("R1 irq", {31'b0, irq_halted}, 32'h0);
      chk("R1 req", {31'b0, txn_req}, 32'h0);

      // R2 table walk
      for (int i = 0; i < 5; i++) begin
         wr(VEC[i][63:32]);
         chk("R2 readback", reg_rdata, VEC[i][31:0]);
      end

      // bulk channel: R3 R4 R12 R8 R11
      wr(32'h8008_0000);
      chk("R3 enable set", {31'b0, reg_rdata[31]}, 32'h1);
      chk("R4 bulk req without strobe", {31'b0, txn_req}, 32'h1);
      wr(32'h0008_0000);
      chk("R3 write zero ignored", {31'b0, reg_rdata[31]}, 32'h1);
      ack();
      chk("R12 req low in flight", {31'b0, txn_req}, 32'h0);
      done(1'b0, 1'b0);
      ack(); done(1'b0, 1'b0);
      ack(); done(1'b0, 1'b0);
      chk("R4 bulk no uf limit", {31'b0, txn_req}, 32'h1);
      ack();
      done(1'b1, 1'b0);
      chk("R8 enable cleared", reg_rdata, 32'h0008_0000);
      chk("R8 irq set", {31'b0, irq_halted}, 32'h1);
      step();
      chk("R11 irq sticky", {31'b0, irq_halted}, 32'h1);
      clr();
      chk("R11 irq cleared", {31'b0, irq_halted}, 32'h0);

      // isochronous odd, count 2: R5 R6 R10
      wr(32'hA024_0000);
      chk("R5 even before strobe blocks", {31'b0, txn_req}, 32'h0);
      ufs(5);
      chk("R5 odd frame allows", {31'b0, txn_req}, 32'h1);
      ack(); done(1'b0, 1'b0);
      chk("R6 second txn allowed", {31'b0, txn_req}, 32'h1);
      ack(); done(1'b0, 1'b0);
      chk("R6 limit reached", {31'b0, txn_req}, 32'h0);
      ufs(6);
      chk("R5 even frame blocks", {31'b0, txn_req}, 32'h0);
      ufs(7);
      chk("R6 tally restarted", {31'b0, txn_req}, 32'h1);
      ack();
      wr(32'hE024_0000);
      chk("R10 abort bit visible", {31'b0, reg_rdata[30]}, 32'h1);
      step(); step();
      chk("R10 no halt before done", {31'b0, irq_halted}, 32'h0);
      done(1'b0, 1'b0);
      chk("R10 no halt at done edge", {31'b0, irq_halted}, 32'h0);
      chk("R10 still enabled", {31'b0, reg_rdata[31]}, 32'h1);
      step();
      chk("R10 halted", {31'b0, irq_halted}, 32'h1);
      chk("R10 bits cleared", reg_rdata, 32'h2024_0000);
      clr();

      // idle abort: R9
      wr(32'h8008_0000);
      wr(32'hC008_0000);
      chk("R9 req dropped", {31'b0, txn_req}, 32'h0);
      chk("R9 no irq yet", {31'b0, irq_halted}, 32'h0);
      step();
      chk("R9 irq", {31'b0, irq_halted}, 32'h1);
      chk("R9 bits cleared", reg_rdata, 32'h0008_0000);
      clr();

      // count 00 as one: R6
      ufs(12);
      wr(32'h8004_0000);
      ack(); done(1'b0, 1'b0);
      chk("R6 count 00 gives one", {31'b0, txn_req}, 32'h0);
      wr(32'hC004_0000);
      step();
      clr();

      // split interrupt, budget 3: R7
      split_en = 1'b1;
      ufs(8);
      wr(32'h803C_0000);
      chk("R7 req", {31'b0, txn_req}, 32'h1);
      ack(); done(1'b0, 1'b0);
      chk("R7 one per uf", {31'b0, txn_req}, 32'h0);
      ufs(10);
      for (int k = 0; k < 3; k++) begin
         ack(); done(1'b0, 1'b1);
         chk("R7 retry allowed", {31'b0, txn_req}, 32'h1);
      end
      ack(); done(1'b0, 1'b1);
      chk("R7 budget spent halts", {31'b0, reg_rdata[31]}, 32'h0);
      chk("R7 irq", {31'b0, irq_halted}, 32'h1);
      split_en = 1'b0;

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule